// File: doc/BRIEF.md
# Banked GPIO Controller with Set/Clear Writes

This block controls 32 general-purpose pads from a simple 32-bit register bus. Each pad has six control bits: output value, output enable, input enable, two alternate-output selects and one alternate-input select. There is also a read-only read-back of the live pad level. Every control register is split into two 16-pin banks. Pins 0 to 15 use the base offset. Pins 16 to 31 use the same offset with 0x80 added.

A write never replaces a bank outright. The lower half of the written word sets control bits and the upper half clears them. Software can therefore change any group of pins in one access, with no read-modify-write and no risk of disturbing pins owned by other code. Pad inputs pass through a two-flop synchronizer before they are read back or handed to an alternate function. Pins 23, 29, 30 and 31 are reserved: they never drive and always read 0.

Top module: `banked_gpio_ctrl`

## Requirements
- R1: After reset every control bit is 0, `pad_oe`, `pad_o`, `alt_in_o` and `rdata` are all 0.
- R2: Register word offsets are 0x00 output value, 0x04 output enable, 0x08 input enable, 0x0C alternate-output 1, 0x10 alternate-output 2, 0x14 alternate-input, 0x18 read-back. A write to the low bank with bit n (n = 0..15) at 1 sets that register's bit of pin n, on the clock edge that accepts the write.
- R3: A write with bit n+16 at 1 clears the control bit of the bank's pin n. Pins whose set and clear bits are both 0 keep their value.
- R4: The high bank sits at the same offset plus 0x80. In it, bit p-16 sets and bit p clears the control bit of pin p (p = 16..31).
- R5: If the set bit and the clear bit of the same pin are both 1 in one write, the pin's control bit ends up 0.
- R6: Pins 23, 29, 30 and 31 ignore all writes. Their control bits, read-back, `pad_oe`, `pad_o` and `alt_in_o` stay 0.
- R7: A read strobe returns the addressed bank's 16 bits in `rdata[15:0]`, with `rdata[31:16]` at 0, one cycle after the strobe. In every cycle not preceded by a strobe `rdata` is 0. Unmapped offsets, and offsets that are not a multiple of 4, read 0.
- R8: `pad_oe` equals the pin's output-enable bit. When output enable is 1, `pad_o` is `alt1_src` if alternate-output 1 is set, else `alt2_src` if alternate-output 2 is set, else the output-value bit. When output enable is 0, `pad_o` is 0.
- R9: Read-back is `pad_i` delayed by a two-flop synchronizer and ANDed with input enable. A read strobe issued one cycle after a pad change still returns the old level, and a strobe issued two cycles after the change returns the new level.
- R10: `alt_in_o` is the synchronized pad input of each pin whose input enable and alternate-input select are both 1, and 0 for every other pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, accepted on the rising edge |
| rd_en | input | 1 | Read strobe; data follows one cycle later |
| addr | input | 8 | Byte address; bit 7 selects the high bank |
| wdata | input | 32 | Write data: set mask in [15:0], clear mask in [31:16] |
| rdata | output | 32 | Registered read data |
| pad_i | input | 32 | Asynchronous pad input levels |
| pad_o | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt1_src | input | 32 | Alternate-function 1 output source per pin |
| alt2_src | input | 32 | Alternate-function 2 output source per pin |
| alt_in_o | output | 32 | Synchronized pad inputs routed to the alternate input function |

## Verification
The bench builds the block with its default parameters: 32 pins in two 16-pin banks, the high bank selected by address bit 7, two synchronizer stages, and reserved pins 23, 29, 30 and 31. With this size, each of the six control registers can be swept pin by pin through both set and clear writes in both banks, and both banks are read back after every write. That reaches every reserved pin and every bank boundary. The pad-drive priorities, the input gating and the exact synchronizer latency are then exercised with a few full-width patterns, and each expected value is computed per pin in the bench.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;

  localparam int BANK_PINS = 16;
  localparam int PIN_COUNT = 2 * BANK_PINS;
  localparam int NUM_CTL   = 6;
  localparam int ADDR_W    = 8;

  typedef enum logic [2:0] {
    CTL_OUT   = 3'd0,
    CTL_OE    = 3'd1,
    CTL_IE    = 3'd2,
    CTL_AOUT1 = 3'd3,
    CTL_AOUT2 = 3'd4,
    CTL_AIN   = 3'd5,
    CTL_RDBK  = 3'd6,
    CTL_NONE  = 3'd7
  } ctl_sel_e;

  // Set mask in the lower half, clear mask in the upper half; clear wins.
  function automatic logic [BANK_PINS-1:0] bank_update(
      input logic [BANK_PINS-1:0]   cur,
      input logic [2*BANK_PINS-1:0] wd,
      input logic [BANK_PINS-1:0]   locked);
    logic [BANK_PINS-1:0] nxt;
    nxt = (cur | wd[BANK_PINS-1:0]) & ~wd[2*BANK_PINS-1:BANK_PINS];
    return nxt & ~locked;
  endfunction

  // Drive value of one pad: alternate 1 beats alternate 2 beats plain value.
  function automatic logic pick_drive(
      input logic oe, input logic a1_sel, input logic a2_sel,
      input logic val, input logic a1_v, input logic a2_v);
    logic d;
    if (!oe)         d = 1'b0;
    else if (a1_sel) d = a1_v;
    else if (a2_sel) d = a2_v;
    else             d = val;
    return d;
  endfunction

endpackage

// File: rtl/gbk_addr_dec.sv
module gbk_addr_dec
  import bgpio_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int HIGH_BIT = 7
) (
  input  logic [AW-1:0] addr,
  output ctl_sel_e      sel,
  output logic          high
);
  localparam int WORD_W = AW - 2;

  logic [AW-1:0]     offs;
  logic [WORD_W-1:0] word;

  always_comb begin
    offs           = addr;
    offs[HIGH_BIT] = 1'b0;
    word           = offs[AW-1:2];
    high           = addr[HIGH_BIT];
    if (offs[1:0] != 2'b00 || word > WORD_W'(CTL_RDBK))
      sel = CTL_NONE;
    else
      sel = ctl_sel_e'(word[2:0]);
  end
endmodule

// File: rtl/gbk_ctl_reg.sv
module gbk_ctl_reg
  import bgpio_pkg::*;
#(
  parameter logic [PIN_COUNT-1:0] LOCKED = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [PIN_COUNT-1:0] wdata,
  output logic [PIN_COUNT-1:0] q
);
  localparam logic [BANK_PINS-1:0] LOCK_LO = LOCKED[BANK_PINS-1:0];
  localparam logic [BANK_PINS-1:0] LOCK_HI = LOCKED[PIN_COUNT-1:BANK_PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q[BANK_PINS-1:0] <= '0;
    else if (wr_lo) q[BANK_PINS-1:0] <= bank_update(q[BANK_PINS-1:0], wdata, LOCK_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q[PIN_COUNT-1:BANK_PINS] <= '0;
    else if (wr_hi) q[PIN_COUNT-1:BANK_PINS] <= bank_update(q[PIN_COUNT-1:BANK_PINS], wdata, LOCK_HI);
  end
endmodule

// File: rtl/gbk_sync.sv
module gbk_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gbk_pad_mux.sv
module gbk_pad_mux
  import bgpio_pkg::*;
#(
  parameter logic [PIN_COUNT-1:0] LOCKED = '0
) (
  input  logic [PIN_COUNT-1:0] out_val,
  input  logic [PIN_COUNT-1:0] out_en,
  input  logic [PIN_COUNT-1:0] a1_sel,
  input  logic [PIN_COUNT-1:0] a2_sel,
  input  logic [PIN_COUNT-1:0] a1_src,
  input  logic [PIN_COUNT-1:0] a2_src,
  output logic [PIN_COUNT-1:0] pad_o,
  output logic [PIN_COUNT-1:0] pad_oe
);
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    if (LOCKED[p]) begin : g_locked
      assign pad_o[p]  = 1'b0;
      assign pad_oe[p] = 1'b0;
    end else begin : g_live
      assign pad_oe[p] = out_en[p];
      assign pad_o[p]  = pick_drive(out_en[p], a1_sel[p], a2_sel[p],
                                    out_val[p], a1_src[p], a2_src[p]);
    end
  end
endmodule

// File: rtl/banked_gpio_ctrl.sv
module banked_gpio_ctrl
  import bgpio_pkg::*;
#(
  parameter logic [PIN_COUNT-1:0] RSVD_MASK   = 32'hE080_0000,
  parameter int                   HIGH_BIT    = 7,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PIN_COUNT-1:0] wdata,
  output logic [PIN_COUNT-1:0] rdata,
  input  logic [PIN_COUNT-1:0] pad_i,
  output logic [PIN_COUNT-1:0] pad_o,
  output logic [PIN_COUNT-1:0] pad_oe,
  input  logic [PIN_COUNT-1:0] alt1_src,
  input  logic [PIN_COUNT-1:0] alt2_src,
  output logic [PIN_COUNT-1:0] alt_in_o
);

  ctl_sel_e sel;
  logic     high;

  gbk_addr_dec #(.AW(ADDR_W), .HIGH_BIT(HIGH_BIT)) u_dec (
    .addr (addr),
    .sel  (sel),
    .high (high)
  );

  // Named events for the checker.
  logic wr_hit;
  logic rd_hit;
  assign wr_hit = wr_en && (sel < CTL_RDBK);
  assign rd_hit = rd_en && (sel != CTL_NONE);

  logic [NUM_CTL-1:0][PIN_COUNT-1:0] ctl_q;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    gbk_ctl_reg #(.LOCKED(RSVD_MASK)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_hit && (sel == ctl_sel_e'(g)) && !high),
      .wr_hi (wr_hit && (sel == ctl_sel_e'(g)) &&  high),
      .wdata (wdata),
      .q     (ctl_q[g])
    );
  end

  logic [PIN_COUNT-1:0] ctl_out, ctl_oe, ctl_ie, ctl_a1, ctl_a2, ctl_ain;
  assign ctl_out = ctl_q[CTL_OUT];
  assign ctl_oe  = ctl_q[CTL_OE];
  assign ctl_ie  = ctl_q[CTL_IE];
  assign ctl_a1  = ctl_q[CTL_AOUT1];
  assign ctl_a2  = ctl_q[CTL_AOUT2];
  assign ctl_ain = ctl_q[CTL_AIN];

  logic [PIN_COUNT-1:0] sync_in;
  logic [PIN_COUNT-1:0] rdbk;

  gbk_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_i),
    .q     (sync_in)
  );

  assign rdbk     = sync_in & ctl_ie & ~RSVD_MASK;
  assign alt_in_o = rdbk & ctl_ain;

  gbk_pad_mux #(.LOCKED(RSVD_MASK)) u_mux (
    .out_val (ctl_out),
    .out_en  (ctl_oe),
    .a1_sel  (ctl_a1),
    .a2_sel  (ctl_a2),
    .a1_src  (alt1_src),
    .a2_src  (alt2_src),
    .pad_o   (pad_o),
    .pad_oe  (pad_oe)
  );

  // Read path: pick the register, then the bank.
  logic [PIN_COUNT-1:0] reg_view;
  logic [BANK_PINS-1:0] bank_view;

  always_comb begin
    reg_view = '0;
    if (sel == CTL_RDBK) reg_view = rdbk;
    for (int i = 0; i < NUM_CTL; i++)
      if (sel == ctl_sel_e'(i)) reg_view = ctl_q[i];
    bank_view = high ? reg_view[PIN_COUNT-1:BANK_PINS] : reg_view[BANK_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_hit) rdata <= {{(PIN_COUNT-BANK_PINS){1'b0}}, bank_view};
    else             rdata <= '0;
  end

endmodule

// File: rtl/banked_gpio_ctrl_chk.sv
module banked_gpio_ctrl_chk
  import bgpio_pkg::*;
#(
  parameter logic [PIN_COUNT-1:0] RSVD_MASK = 32'hE080_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [PIN_COUNT-1:0] wdata,
  input logic [PIN_COUNT-1:0] rdata,
  input logic [PIN_COUNT-1:0] pad_oe,
  input logic [PIN_COUNT-1:0] alt_in_o,
  input logic [PIN_COUNT-1:0] ctl_out,
  input logic [PIN_COUNT-1:0] ctl_ie
);
  localparam logic [ADDR_W-1:0] OUT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OUT_HI = 8'h80;

  // R1: leaving reset, nothing drives and nothing is read.
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && rdata == '0));

  // R2: low-bank set bits land, minus those also cleared.
  a_r2_low_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OUT_LO) |=>
      ((ctl_out[15:0] & $past(wdata[15:0] & ~wdata[31:16] & ~RSVD_MASK[15:0]))
        == $past(wdata[15:0] & ~wdata[31:16] & ~RSVD_MASK[15:0])));

  // R3 and R5: every pin named in the clear half reads 0 afterwards.
  a_r3_clear_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OUT_LO) |=> ((ctl_out[15:0] & $past(wdata[31:16])) == '0));

  // R4: high-bank clear half acts on pins 16..31.
  a_r4_high_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OUT_HI) |=> ((ctl_out[31:16] & $past(wdata[31:16])) == '0));

  // R6: reserved pins never drive nor feed the alternate input.
  a_r6_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | alt_in_o) & RSVD_MASK) == '0);

  // R7: read data only in the cycle after a strobe, upper half always 0.
  a_r7_rdata_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> rdata == '0);
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:16] == '0);

  // R10: alternate input only on pins with input enable.
  a_r10_alt_in_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_in_o & ~ctl_ie) == '0);
endmodule

bind banked_gpio_ctrl banked_gpio_ctrl_chk #(.RSVD_MASK(RSVD_MASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .pad_oe   (pad_oe),
  .alt_in_o (alt_in_o),
  .ctl_out  (ctl_out),
  .ctl_ie   (ctl_ie)
);

// File: tb/banked_gpio_ctrl_tb_top.sv
module banked_gpio_ctrl_tb_top;
  localparam logic [31:0] RSVD = 32'hE080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pad_i = '0, alt1_src = '0, alt2_src = '0;
  logic [31:0] rdata, pad_o, pad_oe, alt_in_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [6];

  always #5 clk = ~clk;

  banked_gpio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe(pad_oe), .alt1_src(alt1_src), .alt2_src(alt2_src),
    .alt_in_o(alt_in_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Bus write; the model is updated pin by pin, clear after set.
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    int r;
    int base;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    r = int'(a[6:0]) / 4;
    base = a[7] ? 16 : 0;
    if (a[1:0] == 2'b00 && r < 6) begin
      for (int k = 0; k < 16; k++) begin
        if (!RSVD[base+k]) begin
          if (d[k])    model[r][base+k] = 1'b1;
          if (d[k+16]) model[r][base+k] = 1'b0;
        end
      end
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  function automatic logic [31:0] bank_of(input logic [31:0] full, input bit hi);
    return hi ? {16'h0, full[31:16]} : {16'h0, full[15:0]};
  endfunction

  // Reads both banks of register r and compares with the model.
  task automatic check_reg(input string req, input int r);
    logic [31:0] v;
    bus_rd(8'(4*r), v);
    check(req, v, bank_of(model[r], 1'b0));
    bus_rd(8'(8'h80 + 4*r), v);
    check(req, v, bank_of(model[r], 1'b1));
  endtask

  function automatic logic [31:0] exp_drive();
    logic [31:0] e;
    for (int p = 0; p < 32; p++) begin
      if (RSVD[p] || !model[1][p]) e[p] = 1'b0;
      else if (model[3][p])        e[p] = alt1_src[p];
      else if (model[4][p])        e[p] = alt2_src[p];
      else                         e[p] = model[0][p];
    end
    return e;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    for (int r = 0; r < 6; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_o", pad_o, '0);
    check("R1 alt_in", alt_in_o, '0);
    check("R1 rdata", rdata, '0);
    for (int r = 0; r < 6; r++) check_reg("R1 ctl", r);

    // R2/R4/R6 set sweep, then R3/R6 clear sweep, over every register and pin
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < 32; p++) begin
        bus_wr(8'((p >= 16 ? 8'h80 : 8'h00) + 4*r), 32'(1) << (p % 16));
        check_reg(RSVD[p] ? "R6 set" : (p < 16 ? "R2 set" : "R4 set"), r);
      end
      for (int p = 0; p < 32; p++) begin
        bus_wr(8'((p >= 16 ? 8'h80 : 8'h00) + 4*r), 32'(1) << (16 + p % 16));
        check_reg(RSVD[p] ? "R6 clear" : "R3 clear", r);
      end
    end

    // R3 untouched pins keep value; R5 set and clear together
    bus_wr(8'h00, 32'h0000_FFFF);
    bus_wr(8'h00, 32'h00F0_0000);
    check_reg("R3 keep", 0);
    bus_wr(8'h84, 32'h0000_0F0F);
    bus_wr(8'h84, 32'h0101_0100);
    check_reg("R5 clear wins", 1);
    bus_wr(8'h00, 32'h0001_0001);
    check_reg("R5 clear wins", 0);

    // R7 unmapped and misaligned reads, and the cycle after a read
    bus_rd(8'h1C, v); check("R7 unmapped", v, '0);
    bus_rd(8'h02, v); check("R7 misaligned", v, '0);
    bus_rd(8'h00, v);
    @(negedge clk);
    check("R7 after read", rdata, '0);
    bus_wr(8'h1C, 32'hFFFF_FFFF);
    for (int r = 0; r < 6; r++) check_reg("R7 unmapped write", r);

    // R8 pad drive under several select patterns
    alt1_src = 32'hA5A5_F00F;
    alt2_src = 32'h3C3C_0FF0;
    bus_wr(8'h04, 32'h0000_FFFF);
    bus_wr(8'h84, 32'h0000_FFFF);
    bus_wr(8'h00, 32'h0000_5A5A);
    bus_wr(8'h80, 32'h0000_C3C3);
    @(negedge clk);
    check("R8 oe", pad_oe, model[1] & ~RSVD);
    check("R8 plain", pad_o, exp_drive());
    bus_wr(8'h10, 32'h0000_FF00);
    bus_wr(8'h90, 32'h0000_00FF);
    @(negedge clk);
    check("R8 alt2", pad_o, exp_drive());
    bus_wr(8'h0C, 32'h0000_F0F0);
    bus_wr(8'h8C, 32'h0000_0F0F);
    @(negedge clk);
    check("R8 alt1 priority", pad_o, exp_drive());
    bus_wr(8'h04, 32'h3333_0000);
    bus_wr(8'h84, 32'h5555_0000);
    @(negedge clk);
    check("R8 oe off", pad_oe, model[1] & ~RSVD);
    check("R8 oe off drive", pad_o, exp_drive());

    // R9 read-back gating and synchronizer latency
    bus_wr(8'h08, 32'h0000_F0FF);
    bus_wr(8'h88, 32'h0000_FFFF);
    @(negedge clk); pad_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    bus_rd(8'h18, v); check("R9 low", v, bank_of(32'hFFFF_FFFF & model[2] & ~RSVD, 1'b0));
    bus_rd(8'h98, v); check("R9 high", v, bank_of(32'hFFFF_FFFF & model[2] & ~RSVD, 1'b1));
    pad_i = 32'h0000_0000;
    bus_rd(8'h18, v); check("R9 one cycle old", v, bank_of(model[2] & ~RSVD, 1'b0));
    pad_i = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_rd(8'h18, v); check("R9 two cycle new", v, bank_of(model[2] & ~RSVD, 1'b0));
    pad_i = 32'h9669_A55A;
    repeat (3) @(negedge clk);
    bus_rd(8'h98, v); check("R9 pattern", v, bank_of(pad_i & model[2] & ~RSVD, 1'b1));

    // R10 alternate input routing
    bus_wr(8'h14, 32'h0000_0FF0);
    bus_wr(8'h94, 32'h0000_FFFF);
    @(negedge clk);
    check("R10 alt in", alt_in_o, pad_i & model[2] & model[5] & ~RSVD);
    bus_wr(8'h88, 32'hFFFF_0000);
    @(negedge clk);
    check("R10 ie off", alt_in_o, pad_i & model[2] & model[5] & ~RSVD);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule